// File: doc/BRIEF.md
# Two-Port Memory with Mailbox Interrupts

This block is a two-port word memory with an interrupt flag for each port. Both ports are synchronous to one clock and can read or write any word on every cycle. The two highest addresses are set aside as mailboxes. The top address belongs to the right port and the one below it belongs to the left port. A port signals the other side by writing a word into the other side's mailbox. That write raises the owner's interrupt line, which is active low. The owner takes the message by reading its own mailbox, and that read drops the interrupt again.

Apart from this side effect, the mailbox words store and return data like any other location. No control register is involved. Each flag is set and cleared only by accesses to its mailbox address. Arbitration between the ports and semaphores are not part of this block.

Top module: `mbox_dpram`

## Requirements
- R1: While reset is asserted, and after it is released, both interrupt outputs read 1 (inactive) and both read-data outputs read 0.
- R2: An access with enable high and write-enable high stores the write data at the address. An access with enable high and write-enable low returns the stored word on that port's read data one cycle later. At all other times the read data holds its value.
- R3: A right-port write to the left mailbox (address all ones except bit 0, 0xFFE with 12 address bits) drives `l_int_n` low in the cycle after the write.
- R4: A left-port write to the right mailbox (address all ones, 0xFFF) drives `r_int_n` low in the cycle after the write.
- R5: A port that reads its own mailbox while its flag is set returns its interrupt output to 1 in the cycle after the read.
- R6: A port writing its own mailbox, reading the other port's mailbox, or accessing any ordinary address leaves both interrupt outputs unchanged.
- R7: When the set of a flag and its clearing read fall in the same cycle, the flag ends up set (interrupt output 0).
- R8: Data written to either mailbox is stored and returned by later reads from either port, in the same way as any other word.
- R9: When both ports write the same address in one cycle, the left port's data is stored. A read in the same cycle as a write by the other port to the same address returns the old contents.
- R10: A set flag stays set through any number of cycles until its owner's mailbox read, whatever other accesses occur.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| l_en | input | 1 | Left port access enable |
| l_we | input | 1 | Left port write (1) or read (0) |
| l_addr | input | ADDR_W | Left port word address |
| l_wdata | input | DATA_W | Left port write data |
| l_rdata | output | DATA_W | Left port read data, one cycle after the read |
| l_int_n | output | 1 | Left port interrupt, active low |
| r_en | input | 1 | Right port access enable |
| r_we | input | 1 | Right port write (1) or read (0) |
| r_addr | input | ADDR_W | Right port word address |
| r_wdata | input | DATA_W | Right port write data |
| r_rdata | output | DATA_W | Right port read data, one cycle after the read |
| r_int_n | output | 1 | Right port interrupt, active low |

## Verification
Each flag is a single register. If it is set or cleared wrongly, the port's interrupt line shows the error on the very next cycle, and the line stays wrong until the next qualifying access corrects it. A mixed-up mailbox decode shows up as an interrupt on the wrong port, or as a line that stays low after the owner reads its mailbox. A memory fault shows as a wrong word on the read data one cycle after a read. Because of this, the stimulus mixes own-mailbox and cross-mailbox accesses, same-cycle set and clear, and same-address writes from both ports, and checks every cycle.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int unsigned MBOX_ADDR_W = 12;
  localparam int unsigned MBOX_DATA_W = 16;
  localparam int unsigned MBOX_PORTS  = 2;
  typedef enum logic {PORT_LEFT = 1'b0, PORT_RIGHT = 1'b1} port_e;
endpackage

// File: rtl/mbox_store.sv
module mbox_store #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_wr,
  input  logic              a_rd,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  input  logic              b_wr,
  input  logic              b_rd,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] a_rdata_d, b_rdata_d;
  logic [DATA_W-1:0] a_rdata_q, b_rdata_q;

  // Array write; port a is written last so it wins a same-address clash.
  always_ff @(posedge clk) begin
    if (b_wr) mem_q[b_addr] <= b_wdata;
    if (a_wr) mem_q[a_addr] <= a_wdata;
  end

  always_comb begin
    a_rdata_d = a_rdata_q;
    b_rdata_d = b_rdata_q;
    if (a_rd) a_rdata_d = mem_q[a_addr];
    if (b_rd) b_rdata_d = mem_q[b_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_rdata_q <= '0;
      b_rdata_q <= '0;
    end else begin
      a_rdata_q <= a_rdata_d;
      b_rdata_q <= b_rdata_d;
    end
  end

  assign a_rdata = a_rdata_q;
  assign b_rdata = b_rdata_q;

  AST_RDATA_A_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !a_rd |=> $stable(a_rdata_q)); // R2
  AST_RDATA_B_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !b_rd |=> $stable(b_rdata_q)); // R2
endmodule

// File: rtl/mbox_flag.sv
module mbox_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic int_no
);
  logic flag_d, flag_q;

  always_comb begin
    flag_d = flag_q;
    if (clr_i) flag_d = 1'b0;
    if (set_i) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign int_no = ~flag_q;

  AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> !int_no); // R7
  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> int_no); // R5
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !set_i) |=> $stable(int_no)); // R10
endmodule

// File: rtl/mbox_dpram.sv
module mbox_dpram
  import mbox_pkg::*;
#(
  parameter int unsigned ADDR_W = MBOX_ADDR_W,
  parameter int unsigned DATA_W = MBOX_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_en,
  input  logic              l_we,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_int_n,
  input  logic              r_en,
  input  logic              r_we,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_int_n
);
  localparam logic [ADDR_W-1:0] BOX_RIGHT = '1;
  localparam logic [ADDR_W-1:0] BOX_LEFT  = {{(ADDR_W-1){1'b1}}, 1'b0};

  logic              wr   [MBOX_PORTS];
  logic              rd   [MBOX_PORTS];
  logic [ADDR_W-1:0] addr [MBOX_PORTS];
  logic [ADDR_W-1:0] box  [MBOX_PORTS];
  logic              set  [MBOX_PORTS];
  logic              clr  [MBOX_PORTS];
  logic              irq_n[MBOX_PORTS];

  assign wr[PORT_LEFT]    = l_en & l_we;
  assign rd[PORT_LEFT]    = l_en & ~l_we;
  assign addr[PORT_LEFT]  = l_addr;
  assign box[PORT_LEFT]   = BOX_LEFT;
  assign wr[PORT_RIGHT]   = r_en & r_we;
  assign rd[PORT_RIGHT]   = r_en & ~r_we;
  assign addr[PORT_RIGHT] = r_addr;
  assign box[PORT_RIGHT]  = BOX_RIGHT;

  mbox_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .a_wr    (wr[PORT_LEFT]),
    .a_rd    (rd[PORT_LEFT]),
    .a_addr  (l_addr),
    .a_wdata (l_wdata),
    .a_rdata (l_rdata),
    .b_wr    (wr[PORT_RIGHT]),
    .b_rd    (rd[PORT_RIGHT]),
    .b_addr  (r_addr),
    .b_wdata (r_wdata),
    .b_rdata (r_rdata)
  );

  for (genvar p = 0; p < MBOX_PORTS; p++) begin : g_port
    localparam int unsigned OTHER = MBOX_PORTS - 1 - p;
    // The other side writes into this port's box; this port reads its own box.
    assign set[p] = wr[OTHER] && (addr[OTHER] == box[p]);
    assign clr[p] = rd[p] && (addr[p] == box[p]);

    mbox_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set[p]),
      .clr_i  (clr[p]),
      .int_no (irq_n[p])
    );
  end

  assign l_int_n = irq_n[PORT_LEFT];
  assign r_int_n = irq_n[PORT_RIGHT];

  AST_LEFT_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(l_int_n) |-> $past(r_en && r_we && (r_addr == BOX_LEFT))); // R3
  AST_RIGHT_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(r_int_n) |-> $past(l_en && l_we && (l_addr == BOX_RIGHT))); // R4
  AST_OWN_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (l_en && l_we && (l_addr == BOX_LEFT) && !(r_en && r_we && (r_addr == BOX_LEFT)))
      |=> $stable(l_int_n)); // R6
endmodule

// File: tb/sim_mbox_dpram.sv
`timescale 1ns/1ps
module sim_mbox_dpram;
  localparam int AW = 12;
  localparam int DW = 16;
  localparam logic [AW-1:0] BL = 12'hFFE;
  localparam logic [AW-1:0] BR = 12'hFFF;

  logic clk = 1'b0;
  logic rst_n;
  logic l_en, l_we, r_en, r_we;
  logic [AW-1:0] l_addr, r_addr;
  logic [DW-1:0] l_wdata, r_wdata, l_rdata, r_rdata;
  logic l_int_n, r_int_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct packed {
    logic          li;
    logic          ri;
    logic          cl;
    logic [DW-1:0] ld;
    logic          cr;
    logic [DW-1:0] rd;
  } exp_t;

  exp_t  q_val[$];
  string q_req[$];

  always #4 clk = ~clk;

  mbox_dpram #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .l_en(l_en), .l_we(l_we), .l_addr(l_addr), .l_wdata(l_wdata),
    .l_rdata(l_rdata), .l_int_n(l_int_n),
    .r_en(r_en), .r_we(r_we), .r_addr(r_addr), .r_wdata(r_wdata),
    .r_rdata(r_rdata), .r_int_n(r_int_n)
  );

  task automatic check(input string req, input string what, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Driver: one access cycle per call, pushing the outputs expected after the edge.
  task automatic cyc(input logic le, input logic lw, input logic [AW-1:0] la,
                     input logic [DW-1:0] ldat, input logic re, input logic rw,
                     input logic [AW-1:0] ra, input logic [DW-1:0] rdat,
                     input logic eli, input logic eri,
                     input logic cl, input logic [DW-1:0] eld,
                     input logic cr, input logic [DW-1:0] erd, input string req);
    exp_t e;
    @(negedge clk);
    l_en = le; l_we = lw; l_addr = la; l_wdata = ldat;
    r_en = re; r_we = rw; r_addr = ra; r_wdata = rdat;
    e.li = eli; e.ri = eri; e.cl = cl; e.ld = eld; e.cr = cr; e.rd = erd;
    q_val.push_back(e);
    q_req.push_back(req);
  endtask

  // Monitor: compares just after each active edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q_val.size() > 0) begin
        exp_t e;
        string r;
        e = q_val.pop_front();
        r = q_req.pop_front();
        check(r, "l_int_n", {15'd0, l_int_n}, {15'd0, e.li});
        check(r, "r_int_n", {15'd0, r_int_n}, {15'd0, e.ri});
        if (e.cl) check(r, "l_rdata", l_rdata, e.ld);
        if (e.cr) check(r, "r_rdata", r_rdata, e.rd);
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    l_en = 0; l_we = 0; l_addr = '0; l_wdata = '0;
    r_en = 0; r_we = 0; r_addr = '0; r_wdata = '0;
    repeat (3) @(negedge clk);
    check("R1", "l_int_n in reset", {15'd0, l_int_n}, 16'd1);
    check("R1", "r_int_n in reset", {15'd0, r_int_n}, 16'd1);
    check("R1", "l_rdata in reset", l_rdata, 16'd0);
    check("R1", "r_rdata in reset", r_rdata, 16'd0);
    rst_n = 1'b1;
    // R1: idle after release
    cyc(0,0,0,0, 0,0,0,0, 1,1, 1,16'h0, 1,16'h0, "R1");
    // R2: plain writes then cross reads
    cyc(1,1,12'h010,16'h1234, 1,1,12'h020,16'hABCD, 1,1, 0,0, 0,0, "R2");
    cyc(1,0,12'h020,0, 1,0,12'h010,0, 1,1, 1,16'hABCD, 1,16'h1234, "R2");
    // R2: read data holds when idle
    cyc(0,0,0,0, 0,0,0,0, 1,1, 1,16'hABCD, 1,16'h1234, "R2");
    // R3: right writes the left box
    cyc(0,0,0,0, 1,1,BL,16'h5A5A, 0,1, 0,0, 0,0, "R3");
    // R10: ordinary read keeps the flag
    cyc(1,0,12'h020,0, 0,0,0,0, 0,1, 1,16'hABCD, 0,0, "R10");
    // R6: left reads the right box, no change
    cyc(1,0,BR,0, 0,0,0,0, 0,1, 0,0, 0,0, "R6");
    // R5 / R8: owner read clears and returns data
    cyc(1,0,BL,0, 0,0,0,0, 1,1, 1,16'h5A5A, 0,0, "R5");
    // R4: left writes the right box
    cyc(1,1,BR,16'h0F0F, 0,0,0,0, 1,0, 0,0, 0,0, "R4");
    // R6: right writes its own box, flag unchanged
    cyc(0,0,0,0, 1,1,BR,16'h1111, 1,0, 0,0, 0,0, "R6");
    // R5 / R8: right reads its own box
    cyc(0,0,0,0, 1,0,BR,0, 1,1, 0,0, 1,16'h1111, "R5");
    // R6: left writes its own box
    cyc(1,1,BL,16'h2222, 0,0,0,0, 1,1, 0,0, 0,0, "R6");
    // R6 / R8: right reads the left box, data returned, no flag change
    cyc(0,0,0,0, 1,0,BL,0, 1,1, 0,0, 1,16'h2222, "R8");
    // R7 / R9: set and clear together; read sees old data
    cyc(1,0,BL,0, 1,1,BL,16'h3333, 0,1, 1,16'h2222, 0,0, "R7");
    cyc(1,0,BL,0, 0,0,0,0, 1,1, 1,16'h3333, 0,0, "R5");
    // R9: same-address write clash, left wins
    cyc(1,1,12'h030,16'hAAAA, 1,1,12'h030,16'hBBBB, 1,1, 0,0, 0,0, "R9");
    cyc(1,0,12'h030,0, 1,0,12'h030,0, 1,1, 1,16'hAAAA, 1,16'hAAAA, "R9");
    cyc(0,0,0,0, 0,0,0,0, 1,1, 0,0, 0,0, "R6");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule